// File: doc/BRIEF.md
# Shift and Word-Operation Execution Unit

This block is one execution slot of a 64-bit integer pipeline. It takes a 32-bit instruction word, two 64-bit source operands and a valid strobe. It decodes the instruction into one of a small set of operation kinds and computes the result in combinational logic. One clock edge later it presents the result, the destination register index, a register-write enable and an illegal-instruction flag. It covers two families of operations. The first is the full-width shifts with an immediate amount. The second is the "word" operations, which add, subtract and shift on the low 32 bits of the operands and always widen their 32-bit outcome to 64 bits by copying bit 31.

The decoder maps each accepted encoding to an enumerated kind: logical left, logical right and arithmetic right on 64 bits, and word add, word subtract, word left, word logical right and word arithmetic right. Any encoding not on that list maps to a reject kind. A reject raises the illegal flag, keeps the write enable low and returns a zero result. When no valid instruction arrives, the registered stage drops the write enable and the illegal flag and keeps its last result and index. The base 32-bit ALU operations, multiply and divide, and the register file belong to other blocks.

Top module: `wsx_exec_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `wr_en`, `illegal`, `result` and `dest_idx` to zero at the next rising edge, whatever the other inputs are.
- R2: Opcode bits 6:0 = 0010011 with bits 14:12 = 001 and bits 31:26 = 000000 shifts `src_a` left by the 6-bit amount in bits 25:20, filling with zeros.
- R3: Opcode 0010011 with bits 14:12 = 101 shifts `src_a` right by the amount in bits 25:20. Bits 31:26 = 000000 fill with zeros, and 010000 fill with bit 63 of `src_a`.
- R4: Opcode 0011011 with bits 14:12 = 000 adds the sign-extended 12-bit immediate in bits 31:20 to the low 32 bits of `src_a`, wrapping modulo 2^32. Bits 63:32 of `src_a` have no effect.
- R5: Opcode 0011011 with bits 14:12 = 001 (left) or 101 (right) shifts the low 32 bits of `src_a` by the 5-bit amount in bits 24:20. Bits 31:25 select the fill: 0000000 for logical and 0100000 for arithmetic from bit 31. Arithmetic is allowed only for right shifts.
- R6: Opcode 0111011 with bits 14:12 = 000 adds (bits 31:25 = 0000000) or subtracts (0100000) the low 32 bits of `src_b` to or from the low 32 bits of `src_a`, wrapping modulo 2^32.
- R7: Opcode 0111011 with bits 14:12 = 001 or 101 shifts the low 32 bits of `src_a` the same way as R5, but the amount is `src_b[4:0]`. Bits 63:5 of `src_b` have no effect.
- R8: Every word operation (opcodes 0011011 and 0111011), including logical right shifts, drives `result[63:32]` with copies of `result[31]`.
- R9: `dest_idx` takes instruction bits 11:7. When that index is zero, `wr_en` stays low while the result is still computed.
- R10: Any other encoding (another opcode, or an unlisted combination of bits 14:12 and 31:25/31:26) raises `illegal`, keeps `wr_en` low and gives `result` = 0.
- R11: The outputs change one cycle after `in_valid`. A cycle without `in_valid` drives `wr_en` and `illegal` low on the next edge and leaves `result` and `dest_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| result | output | 64 | Registered result |
| dest_idx | output | 5 | Registered destination register index |
| wr_en | output | 1 | Registered register-write enable |
| illegal | output | 1 | Registered illegal-instruction flag |

## Verification
The 64-bit shifts are tried with an amount of 36, which needs the sixth amount bit. They are also tried with a negative operand shifted right both logically and arithmetically, which separates zero fill from sign fill, and with the largest amount of 63. Word additions use operands that overflow from bit 31, together with junk in the upper operand half, so a widening that copies the wrong bit or lets the upper half through shows up. Word logical right shifts by zero and by a non-zero amount tell copying bit 31 of the result apart from zero filling. Register-amount shifts use a `src_b` whose bit 5 and above are set, which exposes a shifter that uses more than five bits. Near-miss encodings check the reject path, and cycles with `rd` = 0 or without a valid strobe check that the write enable and the held outputs behave as required.

// File: rtl/wsx_pkg.sv
package wsx_pkg;

    localparam int XLEN = 64;
    localparam int WLEN = 32;
    localparam int REGW = 5;
    localparam int XSHW = $clog2(XLEN);
    localparam int WSHW = $clog2(WLEN);

    localparam logic [6:0] OPC_SHIFT_IMM = 7'b0010011;
    localparam logic [6:0] OPC_WORD_IMM  = 7'b0011011;
    localparam logic [6:0] OPC_WORD_REG  = 7'b0111011;

    localparam logic [2:0] F3_ADD   = 3'b000;
    localparam logic [2:0] F3_LEFT  = 3'b001;
    localparam logic [2:0] F3_RIGHT = 3'b101;

    localparam logic [6:0] F7_PLAIN = 7'b0000000;
    localparam logic [6:0] F7_ALT   = 7'b0100000;
    localparam logic [5:0] F6_PLAIN = 6'b000000;
    localparam logic [5:0] F6_ALT   = 6'b010000;

    typedef enum logic [3:0] {
        K_REJECT,
        K_SLL64,
        K_SRL64,
        K_SRA64,
        K_ADDW,
        K_SUBW,
        K_SLLW,
        K_SRLW,
        K_SRAW
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [REGW-1:0]   rd;
        logic [XSHW-1:0]   amt;
        logic              amt_from_reg;
        logic              imm_sel;
        logic [WLEN-1:0]   imm;
    } dec_t;

endpackage

// File: rtl/wsx_barrel.sv
module wsx_barrel #(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  operand,
    input  logic [SW-1:0] amount,
    input  logic          go_right,
    input  logic          arith,
    output logic [W-1:0]  shifted
);

    logic [W-1:0] flipped_in;
    logic [W-1:0] flipped_out;
    logic [W-1:0] stage [SW+1];
    logic         fill;

    generate
        for (genvar i = 0; i < W; i++) begin : g_flip
            assign flipped_in[i]  = operand[W-1-i];
            assign flipped_out[i] = stage[SW][W-1-i];
        end
    endgenerate

    assign fill     = go_right & arith & operand[W-1];
    assign stage[0] = go_right ? operand : flipped_in;

    generate
        for (genvar k = 0; k < SW; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = amount[k]
                              ? {{STEP{fill}}, stage[k][W-1:STEP]}
                              : stage[k];
        end
    endgenerate

    assign shifted = go_right ? stage[SW] : flipped_out;

endmodule

// File: rtl/wsx_decode.sv
module wsx_decode
    import wsx_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    logic [6:0] opc;
    logic [2:0] minor;
    logic [6:0] upper7;
    logic [5:0] upper6;
    logic [4:0] unused_rs1;

    assign opc        = instr[6:0];
    assign minor      = instr[14:12];
    assign upper7     = instr[31:25];
    assign upper6     = instr[31:26];
    assign unused_rs1 = instr[19:15];

    always_comb begin
        dec              = '0;
        dec.kind         = K_REJECT;
        dec.rd           = instr[11:7];
        dec.imm          = {{(WLEN-12){instr[31]}}, instr[31:20]};
        unique case (opc)
            OPC_SHIFT_IMM: begin
                dec.amt = instr[20 +: XSHW];
                unique case (minor)
                    F3_LEFT: begin
                        if (upper6 == F6_PLAIN) dec.kind = K_SLL64;
                    end
                    F3_RIGHT: begin
                        if (upper6 == F6_PLAIN)    dec.kind = K_SRL64;
                        else if (upper6 == F6_ALT) dec.kind = K_SRA64;
                    end
                    default: dec.kind = K_REJECT;
                endcase
            end
            OPC_WORD_IMM: begin
                dec.amt = {{(XSHW-WSHW){1'b0}}, instr[20 +: WSHW]};
                unique case (minor)
                    F3_ADD: begin
                        dec.kind    = K_ADDW;
                        dec.imm_sel = 1'b1;
                    end
                    F3_LEFT: begin
                        if (upper7 == F7_PLAIN) dec.kind = K_SLLW;
                    end
                    F3_RIGHT: begin
                        if (upper7 == F7_PLAIN)    dec.kind = K_SRLW;
                        else if (upper7 == F7_ALT) dec.kind = K_SRAW;
                    end
                    default: dec.kind = K_REJECT;
                endcase
            end
            OPC_WORD_REG: begin
                dec.amt_from_reg = 1'b1;
                unique case (minor)
                    F3_ADD: begin
                        if (upper7 == F7_PLAIN)    dec.kind = K_ADDW;
                        else if (upper7 == F7_ALT) dec.kind = K_SUBW;
                    end
                    F3_LEFT: begin
                        if (upper7 == F7_PLAIN) dec.kind = K_SLLW;
                    end
                    F3_RIGHT: begin
                        if (upper7 == F7_PLAIN)    dec.kind = K_SRLW;
                        else if (upper7 == F7_ALT) dec.kind = K_SRAW;
                    end
                    default: dec.kind = K_REJECT;
                endcase
            end
            default: dec.kind = K_REJECT;
        endcase
    end

endmodule

// File: rtl/wsx_wordalu.sv
module wsx_wordalu
    import wsx_pkg::*;
(
    input  kind_e             kind,
    input  logic [WLEN-1:0]   opa,
    input  logic [WLEN-1:0]   opb,
    input  logic [WSHW-1:0]   amt,
    output logic [XLEN-1:0]   wide
);

    logic [WLEN-1:0] sh32;
    logic [WLEN-1:0] narrow;
    logic            right;
    logic            arith;

    assign right = (kind == K_SRLW) || (kind == K_SRAW);
    assign arith = (kind == K_SRAW);

    wsx_barrel #(.W(WLEN)) u_sh32 (
        .operand  (opa),
        .amount   (amt),
        .go_right (right),
        .arith    (arith),
        .shifted  (sh32)
    );

    always_comb begin
        unique case (kind)
            K_ADDW:                 narrow = opa + opb;
            K_SUBW:                 narrow = opa - opb;
            K_SLLW, K_SRLW, K_SRAW: narrow = sh32;
            default:                narrow = '0;
        endcase
    end

    assign wide = {{(XLEN-WLEN){narrow[WLEN-1]}}, narrow};

endmodule

// File: rtl/wsx_exec_unit.sv
module wsx_exec_unit
    import wsx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [63:0]      src_a,
    input  logic [63:0]      src_b,
    output logic [63:0]      result,
    output logic [4:0]       dest_idx,
    output logic             wr_en,
    output logic             illegal
);

    dec_t              dec;
    logic [XLEN-1:0]   sh64;
    logic [XLEN-1:0]   word_res;
    logic [WLEN-1:0]   word_b;
    logic [WSHW-1:0]   word_amt;
    logic              right64;
    logic              arith64;
    logic [XLEN-1:0]   nxt_result;
    logic              nxt_wr_en;
    logic              nxt_illegal;
    logic [XLEN-WLEN-1:0] unused_b_hi;

    assign unused_b_hi = src_b[XLEN-1:WLEN];

    wsx_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign right64 = (dec.kind == K_SRL64) || (dec.kind == K_SRA64);
    assign arith64 = (dec.kind == K_SRA64);

    wsx_barrel #(.W(XLEN)) u_sh64 (
        .operand  (src_a),
        .amount   (dec.amt),
        .go_right (right64),
        .arith    (arith64),
        .shifted  (sh64)
    );

    assign word_b   = dec.imm_sel ? dec.imm : src_b[WLEN-1:0];
    assign word_amt = dec.amt_from_reg ? src_b[WSHW-1:0] : dec.amt[WSHW-1:0];

    wsx_wordalu u_word (
        .kind (dec.kind),
        .opa  (src_a[WLEN-1:0]),
        .opb  (word_b),
        .amt  (word_amt),
        .wide (word_res)
    );

    // Output selection by operation kind
    always_comb begin
        nxt_result  = '0;
        nxt_wr_en   = 1'b0;
        nxt_illegal = 1'b0;
        unique case (dec.kind)
            K_SLL64, K_SRL64, K_SRA64: begin
                nxt_result = sh64;
                nxt_wr_en  = (dec.rd != '0);
            end
            K_ADDW, K_SUBW, K_SLLW, K_SRLW, K_SRAW: begin
                nxt_result = word_res;
                nxt_wr_en  = (dec.rd != '0);
            end
            default: begin
                nxt_result  = '0;
                nxt_illegal = 1'b1;
            end
        endcase
    end

    // Registered output stage
    always_ff @(posedge clk) begin
        if (rst) begin
            result   <= '0;
            dest_idx <= '0;
            wr_en    <= 1'b0;
            illegal  <= 1'b0;
        end else if (in_valid) begin
            result   <= nxt_result;
            dest_idx <= dec.rd;
            wr_en    <= nxt_wr_en;
            illegal  <= nxt_illegal;
        end else begin
            wr_en    <= 1'b0;
            illegal  <= 1'b0;
        end
    end

endmodule

// File: rtl/wsx_checker.sv
module wsx_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [63:0] result,
    input logic [4:0]  dest_idx,
    input logic        wr_en,
    input logic        illegal
);

    // R9: a zero destination is never written
    p_rd0_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (dest_idx != 5'd0));

    // R10: a rejected encoding never writes
    p_reject_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wr_en);

    // R11: an idle cycle quiets the strobes
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!wr_en && !illegal));

    // R11: an idle cycle holds the data outputs
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(dest_idx)));

    // R9: index follows the instruction one cycle later
    p_dest_follow_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (dest_idx == $past(instr[11:7])));

    // R8: word results are widened from bit 31
    p_word_widen_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (instr[6:0] == 7'b0011011 || instr[6:0] == 7'b0111011))
        |=> (illegal || result[63:32] == {32{result[31]}}));

    // R10: a rejected encoding yields a zero result
    p_reject_zero_r10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (result == 64'd0));

endmodule

bind wsx_exec_unit wsx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .instr    (instr),
    .result   (result),
    .dest_idx (dest_idx),
    .wr_en    (wr_en),
    .illegal  (illegal)
);

// File: tb/sim_wsx_exec_unit.sv
`timescale 1ns/1ps
module sim_wsx_exec_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [63:0] result;
    logic [4:0]  dest_idx;
    logic        wr_en;
    logic        illegal;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wsx_exec_unit u0 (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .instr    (instr),
        .src_a    (src_a),
        .src_b    (src_b),
        .result   (result),
        .dest_idx (dest_idx),
        .wr_en    (wr_en),
        .illegal  (illegal)
    );

    // {instr, src_a, src_b, expected result}; every row uses rd = 5
    localparam int NV = 16;
    localparam logic [223:0] VEC [NV] = '{
        {32'h02409293, 64'h00000000000000F1, 64'h0, 64'h00000F1000000000}, // R2 left by 36
        {32'h0040D293, 64'h8000000000000010, 64'h0, 64'h0800000000000001}, // R3 logical right 4
        {32'h4040D293, 64'h8000000000000010, 64'h0, 64'hF800000000000001}, // R3 arithmetic right 4
        {32'h43F0D293, 64'h8000000000000010, 64'h0, 64'hFFFFFFFFFFFFFFFF}, // R3 arithmetic right 63
        {32'hFFF0829B, 64'h0000000080000000, 64'h0, 64'h000000007FFFFFFF}, // R4 add -1, wrap
        {32'h0010829B, 64'hFFFFFFFF7FFFFFFF, 64'h0, 64'hFFFFFFFF80000000}, // R4 R8 upper half ignored
        {32'h0040929B, 64'h0000000008000001, 64'h0, 64'hFFFFFFFF80000010}, // R5 word left 4
        {32'h0010D29B, 64'hFFFFFFFF00000002, 64'h0, 64'h0000000000000001}, // R5 word logical right 1
        {32'h0000D29B, 64'h0000000080000000, 64'h0, 64'hFFFFFFFF80000000}, // R8 logical right 0 widens
        {32'h4080D29B, 64'h0000000080000000, 64'h0, 64'hFFFFFFFFFF800000}, // R5 word arithmetic right 8
        {32'h002082BB, 64'h123456787FFFFFFF, 64'h1, 64'hFFFFFFFF80000000}, // R6 add overflow
        {32'h402082BB, 64'h0, 64'h1, 64'hFFFFFFFFFFFFFFFF},                // R6 subtract
        {32'h002092BB, 64'h1, 64'hFFFFFFFFFFFFFFE3, 64'h0000000000000008}, // R7 amount from low 5 bits
        {32'h0020D2BB, 64'h00000000F0000000, 64'h20, 64'hFFFFFFFFF0000000}, // R7 bit 5 ignored
        {32'h0020D2BB, 64'h00000000F0000000, 64'h3C, 64'h000000000000000F}, // R7 R8 right 28
        {32'h4020D2BB, 64'h0000000080000000, 64'h1F, 64'hFFFFFFFFFFFFFFFF}  // R7 arithmetic right 31
    };

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        instr    = ins;
        src_a    = a;
        src_b    = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_reject(input string what, input logic [31:0] ins);
        issue(ins, 64'hDEADBEEF12345678, 64'h3);
        check({what, " illegal"}, {63'd0, illegal}, 64'd1);
        check({what, " wr_en"}, {63'd0, wr_en}, 64'd0);
        check({what, " result"}, result, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        instr    = 32'h0;
        src_a    = 64'h0;
        src_b    = 64'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: state right after reset
        check("R1 reset wr_en", {63'd0, wr_en}, 64'd0);
        check("R1 reset illegal", {63'd0, illegal}, 64'd0);
        check("R1 reset result", result, 64'd0);

        // Vector table: R2 to R8
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][223:192], VEC[i][191:128], VEC[i][127:64]);
            check($sformatf("vector %0d result", i), result, VEC[i][63:0]);
            check($sformatf("vector %0d wr_en", i), {63'd0, wr_en}, 64'd1);
            check($sformatf("vector %0d R9 dest_idx", i), {59'd0, dest_idx}, 64'd5);
        end

        // R11: idle cycle holds the result and index, drops the strobes
        @(negedge clk);
        check("R11 idle wr_en", {63'd0, wr_en}, 64'd0);
        check("R11 idle result held", result, VEC[NV-1][63:0]);
        check("R11 idle dest held", {59'd0, dest_idx}, 64'd5);

        // R9: zero destination, word add
        issue(32'h0020803B, 64'h5, 64'h6);
        check("R9 rd0 wr_en", {63'd0, wr_en}, 64'd0);
        check("R9 rd0 illegal", {63'd0, illegal}, 64'd0);
        check("R9 rd0 result", result, 64'hB);
        check("R9 rd0 dest", {59'd0, dest_idx}, 64'd0);

        // R10: near-miss encodings
        expect_reject("R10 word reg upper 0000001", 32'h022082BB);
        expect_reject("R10 shift opcode minor 000", 32'h00108293);
        expect_reject("R10 64-bit left with alt upper", 32'h40409293);
        expect_reject("R10 word imm left amount bit 25", 32'h0200929B);
        expect_reject("R10 other opcode", 32'h002082B3);

        // R11: a good operation after a reject clears illegal
        issue(32'h0040929B, 64'h1, 64'h0);
        check("R11 recover illegal", {63'd0, illegal}, 64'd0);
        check("R11 recover result", result, 64'h10);

        // R1: reset while outputs are live
        issue(32'h0010829B, 64'h7, 64'h0);
        check("R1 pre-reset wr_en", {63'd0, wr_en}, 64'd1);
        rst      = 1'b1;
        in_valid = 1'b1;
        instr    = 32'h0010829B;
        @(negedge clk);
        check("R1 reset mid-run wr_en", {63'd0, wr_en}, 64'd0);
        check("R1 reset mid-run result", result, 64'd0);
        check("R1 reset mid-run dest", {59'd0, dest_idx}, 64'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule